// File: doc/BRIEF.md
# I2C Master Byte Receiver with Clean Read Termination

This block is the receive datapath of an I2C master. Each read of the data register starts one transfer. The block clocks SCL, samples SDA from the slave on each rising SCL edge and collects the bits into the data register. When the transfer completes, it raises a one-cycle interrupt and drops an active-low pending flag. SCL stays low until software reacts.

The number of bits per transfer comes from a small count field. A field value of zero means a full byte, and any other value means that many bits. An acknowledge-enable input decides whether an extra clock is appended after the data bits. During that extra clock the receiver pulls SDA low.

A read burst ends in three steps:
1. Software clears acknowledge-enable before reading the second-to-last byte, so that byte finishes without an acknowledge clock.
2. Software selects a one-bit count and reads the data register. This produces a single clock during which SDA stays released, and the slave sees a not-acknowledge.
3. After the resulting interrupt, a stop request produces the stop condition and returns the bus to idle.

Top module: `i2c_rx_term_seq`

## Requirements
- R1: After reset, SCL and SDA are released (1), the pending flag `pend_n` is 1, `irq` is 0 and `rx_data` is 0.
- R2: A `rd_strobe` pulse is accepted when the block is idle or when `pend_n` is 0. Acceptance sets `pend_n` to 1 and starts a transfer. A `bit_cnt` value of 3'b000 gives 8 data bits, and values 3'b001 to 3'b111 give that many data bits.
- R3: Each SCL low phase and each SCL high phase lasts exactly HALF_CYC clock cycles. A transfer begins with a low phase.
- R4: SDA is sampled at each rising SCL edge and shifted in MSB first at bit 0 of an 8-bit shift register. `rx_data` takes the register's value when the high phase of the last counted bit ends.
- R5: When `ack_en` was 1 at acceptance, one extra clock follows the data bits and SDA is driven low for that whole clock. When `ack_en` was 0, no extra clock is generated.
- R6: SDA stays released during every data bit. A one-bit transfer with `ack_en` at 0 is therefore a not-acknowledge clock.
- R7: When a transfer completes, `irq` pulses high for one cycle, `pend_n` goes to 0 and SDA is released. SCL is held low for as long as `pend_n` is 0.
- R8: A `stop_req` while `pend_n` is 0 sets `pend_n` to 1 and then runs three phases:
  - SDA is driven low with SCL low for HALF_CYC cycles.
  - SCL is released for HALF_CYC cycles.
  - SDA is released and the block is idle.
- R9: A `rd_strobe` or `stop_req` that arrives during a transfer or a stop is ignored. A `stop_req` while idle is ignored. If `rd_strobe` and `stop_req` arrive together while `pend_n` is 0, the read wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_strobe | input | 1 | One-cycle pulse: data register read, starts a transfer |
| stop_req | input | 1 | One-cycle pulse: request a stop condition |
| ack_en | input | 1 | Append an acknowledge clock with SDA low |
| bit_cnt | input | 3 | Bits per transfer; 0 selects 8 |
| sda_in | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | SCL drive, 1 = released |
| sda_o | output | 1 | SDA drive, 1 = released |
| rx_data | output | 8 | Received data register |
| pend_n | output | 1 | Active-low transfer-pending flag |
| irq | output | 1 | One-cycle transfer-complete pulse |

## Verification
The embedded assertions check the following on every cycle:
- SCL stays low while the pending flag is clear.
- The interrupt is a single-cycle pulse that coincides with the cleared flag and a released SDA.
- SDA never moves during an SCL high phase of a transfer.
- The acknowledge clock drives SDA low.
- The data register changes only at the end of a bit's high phase.
- The phase counter stays in range.

Only the bench's scenarios can show the rest:
- the exact phase lengths;
- the presence or absence of the ninth clock;
- the received values for full bytes and short counts;
- the not-acknowledge termination followed by a stop;
- that reads and stops are ignored at the wrong moments.

// File: rtl/i2crx_pkg.sv
// Package: shared state type for the I2C byte receiver.
// Assumes: one sequencer instance owns the state register.
package i2crx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE   = 3'd0,
        RX_LOW    = 3'd1,
        RX_HIGH   = 3'd2,
        RX_HOLD   = 3'd3,
        RX_STOP_A = 3'd4,
        RX_STOP_B = 3'd5
    } rx_state_e;
endpackage

// File: rtl/i2crx_phase_timer.sv
// Phase timer: divides the system clock into SCL half-periods.
// Produces a one-cycle tick on the last cycle of each phase while run is high.
// Assumes: run drops for at least one cycle between unrelated sequences.
module i2crx_phase_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count cycles within the current phase; restart on tick or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/i2crx_bitcount.sv
// Bit counter: loads the per-transfer bit count and flags the last data bit.
// Assumes: a field value of zero stands for a full data word.
module i2crx_bitcount #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] field,
    input  logic             step,
    output logic             last
);
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(DATA_W);

    logic [CNT_W:0] left;

    assign last = (left == (CNT_W+1)'(1));

    // Hold the number of data bits still to be clocked.
    always_ff @(posedge clk) begin
        if (!rst_n)    left <= '0;
        else if (load) left <= (field == '0) ? FULL : {1'b0, field};
        else if (step && left != '0) left <= left - 1'b1;
    end
endmodule

// File: rtl/i2crx_shifter.sv
// Receive shifter: gathers SDA samples MSB first and copies them to the data register.
// Assumes: shift and latch never occur on the same cycle.
module i2crx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              latch_en,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] shreg;

    // Shift one sampled bit in at the low end.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (shift_en) shreg <= {shreg[DATA_W-2:0], bit_in};
    end

    // Copy the shift register into the visible data register.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_out <= '0;
        else if (latch_en) data_out <= shreg;
    end
endmodule

// File: rtl/i2c_rx_term_seq.sv
// I2C master receive sequencer with acknowledge control and not-acknowledge termination.
// A data-register read starts a transfer of 1..DATA_W bits, optionally followed by an
// acknowledge clock. Completion clears the active-low pending flag and holds SCL low.
// A stop request from the held state produces the stop condition.
// Assumes: rd_strobe and stop_req are single-cycle pulses; sda_in is synchronous.
module i2c_rx_term_seq #(
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 3,
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              stop_req,
    input  logic              ack_en,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              sda_in,
    output logic              scl_o,
    output logic              sda_o,
    output logic [DATA_W-1:0] rx_data,
    output logic              pend_n,
    output logic              irq
);
    import i2crx_pkg::*;

    rx_state_e state;
    logic scl_q, sda_q, pend_q, irq_q;
    logic in_ack, ack_armed;
    logic run, tick, last;
    logic accept_rd, shift_en, step, latch_en;

    assign scl_o  = scl_q;
    assign sda_o  = sda_q;
    assign pend_n = pend_q;
    assign irq    = irq_q;

    // Phase timer runs whenever the bus is being clocked or stopped.
    assign run = (state == RX_LOW) || (state == RX_HIGH) ||
                 (state == RX_STOP_A) || (state == RX_STOP_B);

    // Decode the events that drive the counter and shifter.
    assign accept_rd = rd_strobe && ((state == RX_IDLE) || (state == RX_HOLD));
    assign shift_en  = (state == RX_LOW)  && tick && !in_ack;
    assign step      = (state == RX_HIGH) && tick && !in_ack;
    assign latch_en  = step && last;

    i2crx_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    i2crx_bitcount #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load(accept_rd), .field(bit_cnt),
        .step(step), .last(last)
    );

    i2crx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(sda_in),
        .latch_en(latch_en), .data_out(rx_data)
    );

    // Main sequencer: bus phases, acknowledge slot, pending flag and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            pend_q    <= 1'b1;
            irq_q     <= 1'b0;
            in_ack    <= 1'b0;
            ack_armed <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (state)
                RX_IDLE, RX_HOLD: begin
                    if (accept_rd) begin
                        state     <= RX_LOW;
                        scl_q     <= 1'b0;
                        sda_q     <= 1'b1;
                        pend_q    <= 1'b1;
                        in_ack    <= 1'b0;
                        ack_armed <= ack_en;
                    end else if (state == RX_HOLD && stop_req) begin
                        state  <= RX_STOP_A;
                        sda_q  <= 1'b0;
                        pend_q <= 1'b1;
                    end
                end
                RX_LOW: begin
                    if (tick) begin
                        scl_q <= 1'b1;
                        state <= RX_HIGH;
                    end
                end
                RX_HIGH: begin
                    if (tick) begin
                        scl_q <= 1'b0;
                        if (!in_ack && !last) begin
                            state <= RX_LOW;
                        end else if (!in_ack && ack_armed) begin
                            in_ack <= 1'b1;
                            sda_q  <= 1'b0;
                            state  <= RX_LOW;
                        end else begin
                            in_ack <= 1'b0;
                            sda_q  <= 1'b1;
                            pend_q <= 1'b0;
                            irq_q  <= 1'b1;
                            state  <= RX_HOLD;
                        end
                    end
                end
                RX_STOP_A: begin
                    if (tick) begin
                        scl_q <= 1'b1;
                        state <= RX_STOP_B;
                    end
                end
                RX_STOP_B: begin
                    if (tick) begin
                        sda_q <= 1'b1;
                        state <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R7
    hold_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_n |-> !scl_o);
    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R7
    irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!pend_n && sda_o));
    // R6
    high_sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HIGH) |-> $stable(sda_q));
    // R5
    ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && state == RX_HIGH) |-> !sda_o);
    // R4
    rx_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> $past(state == RX_HIGH));
endmodule

// File: tb/i2c_rx_term_seq_test.sv
// Bench: queue-based behavioural model of the bus waveform, compared every cycle.
module i2c_rx_term_seq_test;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd = 1'b0, stp = 1'b0, ack = 1'b0;
    logic [2:0] cnt = 3'd0;
    logic slave_bit = 1'b1;
    logic sda_bus;
    logic scl_o, sda_o, pend_n, irq;
    logic [7:0] rx_data;

    int checks = 0, errors = 0, cyc = 0;
    string tag = "R1";
    logic [4:0] q[$];        // {scl, sda, pend_n, irq, slave_bit}
    logic [4:0] cur = 5'b11101;
    logic in_hold = 1'b0;
    logic [7:0] exp_rx = 8'h00;

    always #5 clk = ~clk;

    assign sda_bus = sda_o & slave_bit;

    i2c_rx_term_seq #(.HALF_CYC(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd), .stop_req(stp), .ack_en(ack),
        .bit_cnt(cnt), .sda_in(sda_bus), .scl_o(scl_o), .sda_o(sda_o),
        .rx_data(rx_data), .pend_n(pend_n), .irq(irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, expv);
        end
    endtask

    // One cycle: advance model, compare outputs, clear the pulse inputs.
    task automatic tick();
        @(negedge clk);
        rd = 1'b0; stp = 1'b0;
        if (q.size() > 0) cur = q.pop_front();
        else cur[1] = 1'b0;
        slave_bit = cur[0];
        chk("scl", scl_o, cur[4]);
        chk("sda", sda_o, cur[3]);
        chk("pend_n", pend_n, cur[2]);
        chk("irq", irq, cur[1]);
        if (cur[1]) chk("rx_data", rx_data, exp_rx);
    endtask

    task automatic push_n(input logic [4:0] v, input int n);
        for (int i = 0; i < n; i++) q.push_back(v);
    endtask

    task automatic wait_free();
        while (q.size() > 0) tick();
    endtask

    // Issue a read and queue the expected waveform for it.
    task automatic do_read(input logic [2:0] c, input logic a, input logic [7:0] bits, input logic with_stop);
        int n;
        wait_free();
        n = (c == 3'd0) ? 8 : int'(c);
        rd = 1'b1; stp = with_stop; cnt = c; ack = a;
        for (int j = 0; j < n; j++) begin
            logic b;
            b = bits[n-1-j];
            push_n({4'b0110, b}, HALF);
            push_n({4'b1110, b}, HALF);
        end
        if (a) begin
            push_n(5'b00101, HALF);
            push_n(5'b10101, HALF);
        end
        q.push_back(5'b01011);
        exp_rx = 8'((int'(exp_rx) << n) | int'(bits));
        in_hold = 1'b1;
        tick();
    endtask

    task automatic do_stop();
        wait_free();
        stp = 1'b1;
        push_n(5'b00101, HALF);
        push_n(5'b10101, HALF);
        q.push_back(5'b11101);
        in_hold = 1'b0;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        tag = "R1";
        tick();
        chk("rx_data reset", rx_data, 0);
        // R9: stop in idle ignored
        tag = "R9";
        stp = 1'b1;
        repeat (4) tick();
        // R2 R4 R5: full byte with acknowledge
        tag = "R5";
        do_read(3'd0, 1'b1, 8'hA5, 1'b0);
        repeat (5) tick();
        // R9: read and stop while busy are ignored
        tag = "R9";
        rd = 1'b1; tick();
        stp = 1'b1; tick();
        tag = "R3";
        wait_free();
        repeat (3) tick();
        // R4: second byte with acknowledge
        tag = "R4";
        do_read(3'd0, 1'b1, 8'h3C, 1'b0);
        wait_free(); tick();
        // R5: second-to-last byte without acknowledge clock
        tag = "R5";
        do_read(3'd0, 1'b0, 8'h96, 1'b0);
        wait_free(); repeat (2) tick();
        // R6: one-bit not-acknowledge transfer
        tag = "R6";
        do_read(3'd1, 1'b0, 8'h01, 1'b0);
        wait_free(); repeat (2) tick();
        // R7: SCL held low while pending
        tag = "R7";
        repeat (10) tick();
        // R8: stop condition then idle
        tag = "R8";
        do_stop();
        wait_free(); repeat (4) tick();
        // R2: short count from idle with acknowledge
        tag = "R2";
        do_read(3'd3, 1'b1, 8'h05, 1'b0);
        wait_free(); tick();
        // R9: read and stop together, read wins
        tag = "R9";
        do_read(3'd2, 1'b0, 8'h02, 1'b1);
        wait_free(); tick();
        // R8: final stop
        tag = "R8";
        do_stop();
        wait_free(); repeat (3) tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule